// File: doc/BRIEF.md
# Bus master acquisition sequencer

This block sits on an add-in card and wins ownership of a shared system bus for the card's own transfer engine. The engine raises a local request. The sequencer then runs the host's DMA request/acknowledge handshake and asserts the active-low MASTER line only after the host has granted the channel. It turns on the card's address/command drivers one clock later. It tells the engine through a local grant that it may run bus cycles.

Ownership lasts as long as the engine keeps its request raised. When the request falls, the sequencer gives the bus back in a fixed order: drivers off, then MASTER released, then the DMA request withdrawn. If the host withdraws its acknowledge while the card holds the bus, the sequencer drops everything in one clock and pulses an error to the engine. The acknowledge arrives from another clock domain and passes through a synchronizer of `SYNC_STAGES` flops, default 2. All timing below counts clock edges after the input change, with the default depth.

Top module: `busMasterSeq`

## Requirements
- R1: While the synchronous reset is high, and on the clock after it, the outputs are busDreq=0, busMasterN=1, drvEn=0, locGrant=0, locErr=0.
- R2: In idle, with the synchronized acknowledge low, a high locReq makes busDreq go high at the next clock edge. busMasterN stays high while no acknowledge arrives.
- R3: busMasterN falls only after the synchronized acknowledge is seen high. This happens at the 3rd clock edge after busDack rises (SYNC_STAGES+1).
- R4: drvEn and locGrant rise together one clock after busMasterN falls. They are high only while busMasterN is low, in the owning phase.
- R5: busDreq stays high for every cycle in which busMasterN is low.
- R6: When locReq is low in the owning phase, drvEn and locGrant fall at the next edge. busMasterN returns high one clock later, busDreq falls one clock after that, and the block is idle again.
- R7: If the synchronized acknowledge is low while busMasterN is asserted, then at one edge drvEn, locGrant and busDreq all fall and busMasterN goes high. locErr is high for exactly that one clock.
- R8: Outside idle and the owning phase, locReq has no effect. If locReq drops while the block waits for the acknowledge, busDreq stays high, and once the acknowledge comes the acquisition runs to ownership and is then released as in R6.
- R9: A new acquisition starts only when the synchronized acknowledge is low. After busDack falls, busDreq rises no earlier than the 3rd clock edge even if locReq is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous reset, active high |
| locReq | input | 1 | Request and busy indication from the local transfer engine |
| locGrant | output | 1 | High while the engine may run bus cycles |
| locErr | output | 1 | One-clock pulse when ownership was lost |
| busDreq | output | 1 | DMA request to the host, active high |
| busDack | input | 1 | DMA acknowledge from the host, active high, asynchronous |
| busMasterN | output | 1 | MASTER line, active low |
| drvEn | output | 1 | Enable for the card's address/command drivers |

## Verification
The bound checker watches the ordering invariants on every clock:
- MASTER is never low without the request.
- Drivers are never on without MASTER.
- MASTER falls only after a seen acknowledge.
- The normal release keeps its three-step order.
- An error pulse comes only with all lines inactive.

The exact latencies need the bench's timed scenarios: the synchronizer delay before MASTER, the new-request lockout after an acknowledge, and the abort edge. So do the behaviours that depend on local request history: a request dropped during the wait, and the hold for as long as the engine stays busy.

// File: rtl/bms_pkg.sv
package bms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_MSTR   = 3'd2,
    ST_OWN    = 3'd3,
    ST_RELDRV = 3'd4,
    ST_RELMST = 3'd5
  } seqState_t;

  typedef struct packed {
    logic setDreq;
    logic clrDreq;
    logic setMaster;
    logic clrMaster;
    logic setDrv;
    logic clrDrv;
    logic setGrant;
    logic clrGrant;
    logic pulseErr;
  } ctlStrobe_t;

endpackage

// File: rtl/bms_ctrl.sv
module bms_ctrl
  import bms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       locReq,
  input  logic       dackSync,
  output ctlStrobe_t strb
);

  seqState_t curState;
  seqState_t nxtState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    strb     = '0;
    unique case (curState)
      ST_IDLE: begin
        // a fresh request is taken only once the old acknowledge is gone
        if (locReq && !dackSync) begin
          nxtState     = ST_REQ;
          strb.setDreq = 1'b1;
        end
      end
      ST_REQ: begin
        // local request is not looked at while waiting
        if (dackSync) begin
          nxtState       = ST_MSTR;
          strb.setMaster = 1'b1;
        end
      end
      ST_MSTR: begin
        if (!dackSync) begin
          nxtState       = ST_IDLE;
          strb.clrDreq   = 1'b1;
          strb.clrMaster = 1'b1;
          strb.clrDrv    = 1'b1;
          strb.clrGrant  = 1'b1;
          strb.pulseErr  = 1'b1;
        end else begin
          nxtState      = ST_OWN;
          strb.setDrv   = 1'b1;
          strb.setGrant = 1'b1;
        end
      end
      ST_OWN: begin
        if (!dackSync) begin
          nxtState       = ST_IDLE;
          strb.clrDreq   = 1'b1;
          strb.clrMaster = 1'b1;
          strb.clrDrv    = 1'b1;
          strb.clrGrant  = 1'b1;
          strb.pulseErr  = 1'b1;
        end else if (!locReq) begin
          nxtState      = ST_RELDRV;
          strb.clrDrv   = 1'b1;
          strb.clrGrant = 1'b1;
        end
      end
      ST_RELDRV: begin
        if (!dackSync) begin
          nxtState       = ST_IDLE;
          strb.clrDreq   = 1'b1;
          strb.clrMaster = 1'b1;
          strb.clrDrv    = 1'b1;
          strb.clrGrant  = 1'b1;
          strb.pulseErr  = 1'b1;
        end else begin
          nxtState       = ST_RELMST;
          strb.clrMaster = 1'b1;
        end
      end
      ST_RELMST: begin
        // MASTER is already released; withdraw the request last
        nxtState     = ST_IDLE;
        strb.clrDreq = 1'b1;
      end
      default: begin
        nxtState       = ST_IDLE;
        strb.clrDreq   = 1'b1;
        strb.clrMaster = 1'b1;
        strb.clrDrv    = 1'b1;
        strb.clrGrant  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bms_path.sv
module bms_path
  import bms_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busDack,
  input  ctlStrobe_t strb,
  output logic       dackSync,
  output logic       busDreq,
  output logic       busMasterN,
  output logic       drvEn,
  output logic       locGrant,
  output logic       locErr
);

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign dackSync = busDack;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
        end else begin
          chain[0] <= busDack;
          for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign dackSync = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)               busDreq <= 1'b0;
    else if (strb.clrDreq) busDreq <= 1'b0;
    else if (strb.setDreq) busDreq <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 busMasterN <= 1'b1;
    else if (strb.clrMaster) busMasterN <= 1'b1;
    else if (strb.setMaster) busMasterN <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)              drvEn <= 1'b0;
    else if (strb.clrDrv) drvEn <= 1'b0;
    else if (strb.setDrv) drvEn <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                locGrant <= 1'b0;
    else if (strb.clrGrant) locGrant <= 1'b0;
    else if (strb.setGrant) locGrant <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) locErr <= 1'b0;
    else     locErr <= strb.pulseErr;
  end

endmodule

// File: rtl/busMasterSeq.sv
module busMasterSeq
  import bms_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic locReq,
  output logic locGrant,
  output logic locErr,
  output logic busDreq,
  input  logic busDack,
  output logic busMasterN,
  output logic drvEn
);

  ctlStrobe_t strb;
  logic       dackSync;

  bms_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .locReq   (locReq),
    .dackSync (dackSync),
    .strb     (strb)
  );

  bms_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk        (clk),
    .rst        (rst),
    .busDack    (busDack),
    .strb       (strb),
    .dackSync   (dackSync),
    .busDreq    (busDreq),
    .busMasterN (busMasterN),
    .drvEn      (drvEn),
    .locGrant   (locGrant),
    .locErr     (locErr)
  );

endmodule

// File: rtl/bms_chk.sv
module bms_chk (
  input logic clk,
  input logic rst,
  input logic dackSync,
  input logic locGrant,
  input logic locErr,
  input logic busDreq,
  input logic busMasterN,
  input logic drvEn
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (busMasterN && !busDreq && !drvEn && !locGrant && !locErr));

  // R3
  master_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busMasterN) |-> $past(dackSync));

  // R4
  drv_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
    drvEn |-> !busMasterN);

  // R4
  drv_one_late_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drvEn) |-> $past(!busMasterN));

  // R4
  grant_with_drv_chk: assert property (@(posedge clk) disable iff (rst)
    locGrant |-> drvEn);

  // R5
  dreq_held_chk: assert property (@(posedge clk) disable iff (rst)
    !busMasterN |-> busDreq);

  // R6
  drv_before_master_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busMasterN) && !locErr) |-> $past(!drvEn));

  // R6
  master_before_dreq_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busDreq) && !locErr) |-> $past(busMasterN));

  // R7
  abort_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    locErr |-> (busMasterN && !busDreq && !drvEn && !locGrant));

  // R7
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    locErr |=> !locErr);

  // R9
  new_req_after_ack_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busDreq) |-> $past(!dackSync));

endmodule

bind busMasterSeq bms_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dackSync   (dackSync),
  .locGrant   (locGrant),
  .locErr     (locErr),
  .busDreq    (busDreq),
  .busMasterN (busMasterN),
  .drvEn      (drvEn)
);

// File: tb/sim_busMasterSeq.sv
`timescale 1ns/1ps
module sim_busMasterSeq;

  localparam int SYNC   = 2;
  localparam int ACKLAT = SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic locReq = 1'b0;
  logic busDack = 1'b0;
  logic locGrant, locErr, busDreq, busMasterN, drvEn;

  always #2 clk = ~clk;

  busMasterSeq #(.SYNC_STAGES(SYNC)) u0 (
    .clk        (clk),
    .rst        (rst),
    .locReq     (locReq),
    .locGrant   (locGrant),
    .locErr     (locErr),
    .busDreq    (busDreq),
    .busDack    (busDack),
    .busMasterN (busMasterN),
    .drvEn      (drvEn)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic [4:0] vec;
    string      tag;
  } expItem_t;

  expItem_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // vector order: {busDreq, busMasterN, drvEn, locGrant, locErr}
  localparam logic [4:0] IDLE_V = 5'b01000;
  localparam logic [4:0] REQ_V  = 5'b11000;
  localparam logic [4:0] MST_V  = 5'b10000;
  localparam logic [4:0] OWN_V  = 5'b10110;
  localparam logic [4:0] ERR_V  = 5'b01001;

  task automatic expectAt(int off, logic [4:0] v, string tag);
    expItem_t e;
    e.at  = cyc + off;
    e.vec = v;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare scoreboard items due in this cycle
  always @(negedge clk) begin
    logic [4:0] got;
    got = {busDreq, busMasterN, drvEn, locGrant, locErr};
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (got !== sb[i].vec) begin
          errors++;
          $display("FAIL %s cyc=%0d got dreq,mstN,drv,gnt,err=%b expected %b",
                   sb[i].tag, cyc, got, sb[i].vec);
        end
        sb.delete(i);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    tick(1);
    // R1: reset state, during and after reset
    expectAt(1, IDLE_V, "R1 in reset");
    expectAt(2, IDLE_V, "R1 in reset");
    tick(3);
    rst = 1'b0;
    expectAt(1, IDLE_V, "R1 after reset");
    expectAt(2, IDLE_V, "R1 after reset");
    tick(2);

    // R2..R6: normal acquisition, hold, release
    locReq = 1'b1;
    expectAt(1, REQ_V, "R2 request out");
    for (int k = 2; k <= 4; k++) expectAt(k, REQ_V, "R2 no master without ack");
    tick(4);
    busDack = 1'b1;
    for (int k = 1; k < ACKLAT; k++) expectAt(k, REQ_V, "R3 ack not yet seen");
    expectAt(ACKLAT, MST_V, "R3 master after ack");
    expectAt(ACKLAT + 1, OWN_V, "R4 drivers one late");
    tick(ACKLAT + 1);
    for (int k = 1; k <= 5; k++) expectAt(k, OWN_V, "R5 held while busy");
    tick(5);
    locReq = 1'b0;
    expectAt(1, MST_V, "R6 drivers off first");
    expectAt(2, REQ_V, "R6 master released");
    expectAt(3, IDLE_V, "R6 request dropped");
    tick(3);

    // R9: request waits for the old acknowledge to clear
    busDack = 1'b0;
    locReq  = 1'b1;
    for (int k = 1; k < ACKLAT; k++) expectAt(k, IDLE_V, "R9 lockout");
    expectAt(ACKLAT, REQ_V, "R9 request after ack low");
    tick(ACKLAT + 1);

    // R8: dropping the local request while waiting has no effect
    locReq = 1'b0;
    for (int k = 1; k <= 3; k++) expectAt(k, REQ_V, "R8 request kept");
    tick(3);
    busDack = 1'b1;
    expectAt(ACKLAT, MST_V, "R8 master despite drop");
    expectAt(ACKLAT + 1, OWN_V, "R8 reaches ownership");
    expectAt(ACKLAT + 2, MST_V, "R6 release after R8");
    expectAt(ACKLAT + 3, REQ_V, "R6 release after R8");
    expectAt(ACKLAT + 4, IDLE_V, "R6 release after R8");
    tick(ACKLAT + 4);
    busDack = 1'b0;
    tick(ACKLAT + 1);

    // R7: acknowledge lost while owning
    locReq = 1'b1;
    expectAt(1, REQ_V, "R2 request out");
    tick(1);
    busDack = 1'b1;
    expectAt(ACKLAT, MST_V, "R3 master after ack");
    expectAt(ACKLAT + 1, OWN_V, "R4 drivers one late");
    tick(ACKLAT + 3);
    busDack = 1'b0;
    for (int k = 1; k < ACKLAT; k++) expectAt(k, OWN_V, "R7 before loss seen");
    expectAt(ACKLAT, ERR_V, "R7 abort");
    tick(ACKLAT);
    locReq = 1'b0;
    expectAt(1, IDLE_V, "R7 error one cycle");
    expectAt(2, IDLE_V, "R7 stays idle");
    tick(4);

    if (sb.size() != 0) begin
      for (int i = 0; i < sb.size(); i++) begin
        checks++;
        errors++;
        $display("FAIL %s: got unchecked expected checked", sb[i].tag);
      end
    end
    finishRun();
  end

endmodule